// File: doc/BRIEF.md
# Per-Channel Output Power Sequencer

This block turns a level-sensitive power-down request vector, one bit per output channel, into an ordered series of control-word updates for a multi-channel converter. Each channel's control word holds three enable bits: internal circuitry, DC-DC converter and output driver. When a channel is brought up, the block first sets the internal and DC-DC enables. It then waits a fixed settling interval and sets the output enable in a second update. When a channel is taken down, all three enables are cleared in a single update.

The block keeps a shadow copy of every channel's control word, and each update is a read-modify-write of that copy through set and clear masks. Bits other than the enables (range, mode and similar) are kept as they are. Those other bits are loaded through a small configuration write port and are carried out with the next update of that channel. Each update leaves the block as a one-cycle strobe with channel index and full word, for a downstream register or serial writer. Channels are served one at a time, lowest index first.

Top module: `chan_pwr_seq`

## Requirements
- R1: A power-up produces a first update whose word has the internal enable (bit 8) and the DC-DC enable (bit 4) set and the output enable (bit 6) clear.
- R2: The second power-up update sets bit 6, with bits 8 and 4 still set. Its strobe comes exactly SETTLE_CYC = CLK_FREQ_KHZ*SETTLE_US/1000 cycles after the first strobe.
- R3: A power-down produces exactly one update, in which bits 8, 6 and 4 are all clear.
- R4: A request bit equal to the channel's current power state produces no update.
- R5: After reset every channel is powered down (`pd_state` all ones), no strobe is issued and every shadow word is zero.
- R6: Bits of the word other than 8, 6 and 4 keep the value last loaded by a configuration write. Enable-bit values in a configuration write are ignored.
- R7: When several channels need service, they are handled one at a time in ascending index order, and a channel's full power-up finishes before the next channel starts.
- R8: `busy` is high while a settling wait is running or while any request bit differs from `pd_state`, and low otherwise.
- R9: A power-down request for the channel in its settling wait ends the wait with a single update clearing bits 8, 6 and 4, and no output-enable update follows.
- R10: `pd_state` changes by at most one bit per cycle. The bit is cleared with the first power-up update and set with a power-down update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | NCH | Requested state per channel, 1 = powered down |
| cfg_we | input | 1 | Load non-enable bits of one shadow word |
| cfg_chan | input | CH_W | Channel for the configuration load |
| cfg_bits | input | CTRL_W | Configuration value; enable bit positions ignored |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_chan | output | CH_W | Channel of the update |
| upd_word | output | CTRL_W | Full control word after the update |
| pd_state | output | NCH | Current power state per channel, 1 = down |
| busy | output | 1 | A sequence is running or pending |

## Verification
The assertions assume that `pd_req` may change at any cycle. They also assume that configuration loads arrive only while the block is idle, because the preservation check compares the update word with the last value loaded. The stimulus keeps to this by loading configuration only after `busy` has fallen, and it lets every request pattern complete before the next one is applied. The exception is one directed case that withdraws a power-up during the settling wait to exercise the abort path. The settling window is checked with a cycle counter in the checker, not with a deep history lookup.

// File: rtl/chan_pwr_seq_pkg.sv
// Shared constants and types for the channel power sequencer.
// Assumes a control word of at least 9 bits, so that all enable positions exist.
package chan_pwr_seq_pkg;
    localparam int EN_INT_POS  = 8;
    localparam int EN_OUT_POS  = 6;
    localparam int EN_DCDC_POS = 4;

    typedef enum logic [0:0] {
        SQ_IDLE   = 1'b0,
        SQ_SETTLE = 1'b1
    } seq_state_t;

    // Build a mask with the selected enable positions set.
    function automatic logic [31:0] en_mask(input logic with_int, input logic with_out,
                                            input logic with_dcdc);
        logic [31:0] m;
        m = '0;
        m[EN_INT_POS]  = with_int;
        m[EN_OUT_POS]  = with_out;
        m[EN_DCDC_POS] = with_dcdc;
        return m;
    endfunction
endpackage

// File: rtl/cps_pick.sv
// Picks the lowest-indexed channel whose request differs from its power state.
// Purely combinational. Assumes NCH >= 1.
module cps_pick #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  req,
    input  logic [NCH-1:0]  state,
    output logic            found,
    output logic [CH_W-1:0] idx,
    output logic            want_down
);
    logic [NCH-1:0] diff;

    assign diff = req ^ state;

    // Scan from the top so that the lowest mismatching index wins.
    always_comb begin
        found     = 1'b0;
        idx       = '0;
        want_down = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (diff[i]) begin
                found     = 1'b1;
                idx       = CH_W'(i);
                want_down = req[i];
            end
        end
    end
endmodule

// File: rtl/cps_settle_timer.sv
// Down-counter for the power-up settling interval.
// A start loads the count; expired is high for the cycle in which the count
// has reached zero while running. A stop abandons the count.
module cps_settle_timer #(
    parameter int SETTLE_CYC = 50000,
    parameter int CNT_W      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Load, count down and clear the settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (stop) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(SETTLE_CYC - 1);
            run_q <= 1'b1;
        end else if (run_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/cps_shadow_bank.sv
// Holds one shadow control word per channel.
// A configuration load replaces the non-enable bits of one word. An update
// applies set and clear masks to one word. Both may hit the same word in one
// cycle: the load is merged first, then the masks. upd_next shows the word
// the update will leave behind, for registering by the caller.
module cps_shadow_bank
    import chan_pwr_seq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int CTRL_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [CTRL_W-1:0] cfg_bits,
    input  logic              upd_en,
    input  logic [CH_W-1:0]   upd_chan,
    input  logic [CTRL_W-1:0] set_mask,
    input  logic [CTRL_W-1:0] clr_mask,
    output logic [CTRL_W-1:0] upd_next
);
    localparam logic [CTRL_W-1:0] EN_ALL = CTRL_W'(en_mask(1'b1, 1'b1, 1'b1));

    logic [CTRL_W-1:0] word_q [NCH];
    logic [CTRL_W-1:0] word_d [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_word
        logic [CTRL_W-1:0] merged;

        // Merge a configuration load, then apply the update masks.
        always_comb begin
            merged = word_q[g];
            if (cfg_we && cfg_chan == CH_W'(g))
                merged = (cfg_bits & ~EN_ALL) | (word_q[g] & EN_ALL);
            word_d[g] = merged;
            if (upd_en && upd_chan == CH_W'(g))
                word_d[g] = (merged | set_mask) & ~clr_mask;
        end

        // Store the channel's shadow word.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q[g] <= '0;
            else        word_q[g] <= word_d[g];
        end
    end

    // Select the post-update word of the addressed channel.
    always_comb begin
        upd_next = '0;
        for (int i = 0; i < NCH; i++)
            if (upd_chan == CH_W'(i)) upd_next = word_d[i];
    end
endmodule

// File: rtl/chan_pwr_seq.sv
// Per-channel output power sequencer.
// Compares the request vector with the tracked power state, serves one channel
// at a time (lowest index first) and issues registered update strobes.
// Power-up is two updates separated by the settling wait; power-down is one.
// Assumes NCH >= 2 and a settling time of at least one cycle.
module chan_pwr_seq
    import chan_pwr_seq_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int CTRL_W       = 13,
    parameter int CLK_FREQ_KHZ = 250000,
    parameter int SETTLE_US    = 200,
    localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pd_req,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [CTRL_W-1:0] cfg_bits,
    output logic              upd_valid,
    output logic [CH_W-1:0]   upd_chan,
    output logic [CTRL_W-1:0] upd_word,
    output logic [NCH-1:0]    pd_state,
    output logic              busy
);
    localparam int SETTLE_RAW = (CLK_FREQ_KHZ * SETTLE_US) / 1000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int CNT_W      = $clog2(SETTLE_CYC + 1);
    localparam logic [CTRL_W-1:0] M_UP1  = CTRL_W'(en_mask(1'b1, 1'b0, 1'b1));
    localparam logic [CTRL_W-1:0] M_UP2  = CTRL_W'(en_mask(1'b0, 1'b1, 1'b0));
    localparam logic [CTRL_W-1:0] M_DOWN = CTRL_W'(en_mask(1'b1, 1'b1, 1'b1));

    seq_state_t        state_q, state_d;
    logic [CH_W-1:0]   cur_q, cur_d;
    logic [NCH-1:0]    pd_q, pd_d;
    logic              pick_found, pick_down;
    logic [CH_W-1:0]   pick_idx;
    logic              tmr_start, tmr_stop, tmr_exp;
    logic              act_en;
    logic [CH_W-1:0]   act_chan;
    logic [CTRL_W-1:0] act_set, act_clr, act_word;
    logic              vld_q;
    logic [CH_W-1:0]   chan_q;
    logic [CTRL_W-1:0] word_q;

    cps_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .req       (pd_req),
        .state     (pd_q),
        .found     (pick_found),
        .idx       (pick_idx),
        .want_down (pick_down)
    );

    cps_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .stop    (tmr_stop),
        .expired (tmr_exp)
    );

    cps_shadow_bank #(.NCH(NCH), .CH_W(CH_W), .CTRL_W(CTRL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_chan (cfg_chan),
        .cfg_bits (cfg_bits),
        .upd_en   (act_en),
        .upd_chan (act_chan),
        .set_mask (act_set),
        .clr_mask (act_clr),
        .upd_next (act_word)
    );

    // Decide the next action: start a sequence, finish it, or abort it.
    always_comb begin
        state_d   = state_q;
        cur_d     = cur_q;
        pd_d      = pd_q;
        act_en    = 1'b0;
        act_chan  = pick_idx;
        act_set   = '0;
        act_clr   = '0;
        tmr_start = 1'b0;
        tmr_stop  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (pick_found) begin
                    act_en = 1'b1;
                    if (pick_down) begin
                        act_clr        = M_DOWN;
                        pd_d[pick_idx] = 1'b1;
                    end else begin
                        act_set        = M_UP1;
                        pd_d[pick_idx] = 1'b0;
                        tmr_start      = 1'b1;
                        cur_d          = pick_idx;
                        state_d        = SQ_SETTLE;
                    end
                end
            end
            SQ_SETTLE: begin
                act_chan = cur_q;
                if (pd_req[cur_q]) begin
                    act_en      = 1'b1;
                    act_clr     = M_DOWN;
                    pd_d[cur_q] = 1'b1;
                    tmr_stop    = 1'b1;
                    state_d     = SQ_IDLE;
                end else if (tmr_exp) begin
                    act_en   = 1'b1;
                    act_set  = M_UP2;
                    tmr_stop = 1'b1;
                    state_d  = SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // Sequence state, tracked power state and the registered update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cur_q   <= '0;
            pd_q    <= '1;
            vld_q   <= 1'b0;
            chan_q  <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            pd_q    <= pd_d;
            vld_q   <= act_en;
            if (act_en) begin
                chan_q <= act_chan;
                word_q <= act_word;
            end
        end
    end

    assign upd_valid = vld_q;
    assign upd_chan  = chan_q;
    assign upd_word  = word_q;
    assign pd_state  = pd_q;
    assign busy      = (state_q == SQ_SETTLE) || (pd_req != pd_q);
endmodule

// File: rtl/chan_pwr_seq_chk.sv
// Property checker for the channel power sequencer, bound to every instance.
// Assumes configuration loads happen only while the block is idle.
module chan_pwr_seq_chk #(
    parameter int NCH        = 4,
    parameter int CTRL_W     = 13,
    parameter int CH_W       = 2,
    parameter int SETTLE_CYC = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic [CH_W-1:0]   upd_chan,
    input logic [CTRL_W-1:0] upd_word,
    input logic [NCH-1:0]    pd_state,
    input logic              busy
);
    logic [31:0] gap_q;

    // Count cycles since the most recent first-step power-up strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (upd_valid && upd_word[8] && !upd_word[6])
            gap_q <= 32'd1;
        else if (gap_q != '0)
            gap_q <= gap_q + 32'd1;
    end

    // R1: a strobe for a channel that is up carries internal and DC-DC enables
    p_up_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !pd_state[upd_chan]) |-> (upd_word[8] && upd_word[4]));

    // R2: the output-enable strobe comes exactly one settling interval later
    p_settle_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_word[6]) |-> (gap_q == 32'(SETTLE_CYC)));

    // R3: a strobe for a channel that is down has every enable clear
    p_down_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && pd_state[upd_chan]) |->
            (!upd_word[8] && !upd_word[6] && !upd_word[4]));

    // R4: nothing pending means no strobe next cycle
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !upd_valid);

    // R10: the tracked power state moves one channel at a time
    p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pd_state ^ $past(pd_state)) <= 1);

    // R10: any change of the power state comes with a strobe
    p_state_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_state != $past(pd_state)) |-> upd_valid);
endmodule

bind chan_pwr_seq chan_pwr_seq_chk #(
    .NCH        (NCH),
    .CTRL_W     (CTRL_W),
    .CH_W       (CH_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_chan  (upd_chan),
    .upd_word  (upd_word),
    .pd_state  (pd_state),
    .busy      (busy)
);

// File: tb/chan_pwr_seq_tb.sv
module chan_pwr_seq_tb;
    localparam int NCH    = 4;
    localparam int CTRL_W = 13;
    localparam int CH_W   = 2;
    localparam int KHZ    = 100;
    localparam int US     = 200;
    localparam int SETTLE = KHZ * US / 1000;
    localparam logic [CTRL_W-1:0] EN = 13'h150;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    pd_req = '1;
    logic              cfg_we = 1'b0;
    logic [CH_W-1:0]   cfg_chan = '0;
    logic [CTRL_W-1:0] cfg_bits = '0;
    logic              upd_valid;
    logic [CH_W-1:0]   upd_chan;
    logic [CTRL_W-1:0] upd_word;
    logic [NCH-1:0]    pd_state;
    logic              busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ev_n = 0;
    int ev_ch [256];
    int ev_w  [256];
    int ev_t  [256];
    logic [CTRL_W-1:0] mcfg [NCH];
    bit done = 1'b0;

    chan_pwr_seq #(.NCH(NCH), .CTRL_W(CTRL_W), .CLK_FREQ_KHZ(KHZ), .SETTLE_US(US)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_bits(cfg_bits), .upd_valid(upd_valid), .upd_chan(upd_chan),
        .upd_word(upd_word), .pd_state(pd_state), .busy(busy)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every strobe away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && upd_valid) begin
            ev_ch[ev_n % 256] = int'(upd_chan);
            ev_w[ev_n % 256]  = int'(upd_word);
            ev_t[ev_n % 256]  = cyc;
            ev_n = ev_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected final word of a channel from its configuration and power state.
    function automatic int exp_word(input int ch, input bit up);
        return int'(mcfg[ch] | (up ? EN : 13'h0));
    endfunction

    function automatic int exp_events(input logic [NCH-1:0] from, input logic [NCH-1:0] to);
        int n = 0;
        for (int i = 0; i < NCH; i++)
            if (from[i] != to[i]) n += to[i] ? 1 : 2;
        return n;
    endfunction

    task automatic settle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic load_cfg(input int ch, input logic [CTRL_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = CH_W'(ch); cfg_bits = v;
        mcfg[ch] = v & ~EN;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        int n0;
        logic [NCH-1:0] oldp, newp;
        void'($urandom(32'h5EED));
        for (int i = 0; i < NCH; i++) mcfg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        chk(pd_state == 4'hF, "R5 state", pd_state, 4'hF);
        chk(!upd_valid && ev_n == 0, "R5 strobe", ev_n, 0);
        chk(!busy, "R8 idle after reset", busy, 0);

        // R6 config with enable bits that must be ignored; R1/R2 power-up of channel 2
        load_cfg(2, 13'h1F5);
        n0 = ev_n;
        @(negedge clk); pd_req[2] = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy, "R8 busy in wait", busy, 1);
        settle();
        chk(ev_n - n0 == 2, "R2 two updates", ev_n - n0, 2);
        chk(ev_ch[n0] == 2 && ev_w[n0] == 'h1B5, "R1 first word", ev_w[n0], 'h1B5);
        chk(ev_w[n0+1] == 'h1F5, "R6 second word", ev_w[n0+1], 'h1F5);
        chk(ev_t[n0+1] - ev_t[n0] == SETTLE, "R2 gap", ev_t[n0+1] - ev_t[n0], SETTLE);
        chk(pd_state == 4'hB, "R10 state", pd_state, 4'hB);

        // R4 same request: nothing happens
        n0 = ev_n;
        repeat (10) @(negedge clk);
        chk(ev_n == n0, "R4 no update", ev_n - n0, 0);

        // R3 power-down
        n0 = ev_n;
        pd_req[2] = 1'b1;
        settle();
        chk(ev_n - n0 == 1 && ev_w[n0] == 'h0A5, "R3 down word", ev_w[n0], 'h0A5);

        // R7 ordering with three channels at once
        n0 = ev_n;
        pd_req = 4'b0100;
        settle();
        chk(ev_n - n0 == 6, "R7 count", ev_n - n0, 6);
        chk(ev_ch[n0] == 0 && ev_ch[n0+1] == 0 && ev_ch[n0+2] == 1 &&
            ev_ch[n0+3] == 1 && ev_ch[n0+4] == 3 && ev_ch[n0+5] == 3,
            "R7 order", ev_ch[n0+4], 3);
        chk(ev_w[n0] == 'h110 && ev_w[n0+1] == 'h150, "R7 words", ev_w[n0+1], 'h150);

        // R9 abort during the settling wait
        pd_req[0] = 1'b1;
        settle();
        n0 = ev_n;
        pd_req[0] = 1'b0;
        repeat (5) @(negedge clk);
        pd_req[0] = 1'b1;
        settle();
        chk(ev_n - n0 == 2, "R9 count", ev_n - n0, 2);
        chk(ev_w[n0+1] == 0 && ev_ch[n0+1] == 0, "R9 abort word", ev_w[n0+1], 0);
        chk(pd_state[0] == 1'b1, "R9 state", pd_state, 1);

        // Random request patterns with configuration loads in between
        for (int it = 0; it < 40; it++) begin
            int c;
            c = $urandom % NCH;
            load_cfg(c, CTRL_W'($urandom));
            oldp = pd_state;
            newp = NCH'($urandom);
            n0 = ev_n;
            @(negedge clk); pd_req = newp;
            settle();
            chk(pd_state == newp, "R10 random state", pd_state, newp);
            chk(ev_n - n0 == exp_events(oldp, newp), "R7 random count",
                ev_n - n0, exp_events(oldp, newp));
            for (int ch = 0; ch < NCH; ch++) begin
                if (oldp[ch] != newp[ch]) begin
                    int last = -1;
                    for (int k = n0; k < ev_n; k++)
                        if (ev_ch[k % 256] == ch) last = ev_w[k % 256];
                    chk(last == exp_word(ch, !newp[ch]), "R6 random word",
                        last, exp_word(ch, !newp[ch]));
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule